// File: doc/BRIEF.md
# Skewed Two-Stage Ripple Adder

This block adds two 4-bit operands and an incoming carry with a ripple-carry chain of full adders that is cut in the middle by a register. The lower two bits of an addition are presented one clock ahead of the upper two bits. The carry leaving bit 1 is held in a register for one cycle, and the upper half uses it together with its own operand bits. Because of this split, the clock period only has to cover half of the carry chain. A fresh addition can enter on every clock, so the block delivers one result per clock.

Each half has its own operand lanes and its own valid flag. The sum leaves in the same staggered form: the lower result bits appear one cycle before the upper result bits and the final carry. A consumer that expects this stagger can take the halves directly. It pairs the halves by their valid flags, one cycle apart.

Top module: `skew_pipe_adder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both output valid flags, both sum halves, the final carry and the internal carry register. The first edge after reset therefore sees a carry of 0.
- R2: One clock after the low lane is presented with `lo_in_vld` high, `lo_sum` equals `(lo_a + lo_b + lo_cin) mod 2^HALF_W`.
- R3: `lo_out_vld` equals the value `lo_in_vld` had one clock earlier.
- R4: One clock after the high lane is presented, when the low lane was valid on the cycle before it, `hi_sum` equals the low `HALF_W` bits of `hi_a + hi_b + k`. Here `k` is the carry out of the low-lane addition presented on that earlier cycle.
- R5: Under the same conditions as R4, `hi_cout` equals bit `HALF_W` of `hi_a + hi_b + k`, which is the carry out of the whole 4-bit addition.
- R6: `hi_out_vld` equals the value `hi_in_vld` had one clock earlier.
- R7: When the low lane was not valid on the cycle before the high lane is presented, the carry into the high half is 0, whatever data sat on the low lanes. One clock later, `{hi_cout, hi_sum}` equals `hi_a + hi_b`.
- R8: Consider additions presented back to back on every clock, each with its low half in cycle t and its high half in cycle t+1. For each of them, `{hi_cout, hi_sum}` seen after cycle t+1, joined above `lo_sum` seen after cycle t, equals `A + B + cin` as a 5-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lo_a | input | HALF_W | Operand A, low half |
| lo_b | input | HALF_W | Operand B, low half |
| lo_cin | input | 1 | Carry into bit 0 |
| lo_in_vld | input | 1 | Low lanes hold valid data |
| hi_a | input | HALF_W | Operand A, high half (one cycle after its low half) |
| hi_b | input | HALF_W | Operand B, high half |
| hi_in_vld | input | 1 | High lanes hold valid data |
| lo_sum | output | HALF_W | Registered sum, low half |
| lo_out_vld | output | 1 | `lo_sum` is valid |
| hi_sum | output | HALF_W | Registered sum, high half (one cycle after the low half) |
| hi_cout | output | 1 | Final carry out, aligned with `hi_sum` |
| hi_out_vld | output | 1 | `hi_sum` and `hi_cout` are valid |

## Verification
The low half of a result is due one clock after its low operands are presented. The high half is due one clock after its high operands, which is two clocks after the low operands of the same addition. The bench drives inputs on the falling edge and reads outputs on the next falling edge, one rising edge later. It keeps a one-cycle history of its own stimulus for the low and high lanes. It keeps a two-cycle history of the low lanes to work out the carry the high half should have received. For the full-width check it joins the high half with the low sum it recorded one cycle before.

// File: rtl/skew_pipe_adder.sv
module skew_pipe_adder #(
  parameter int HALF_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HALF_W-1:0] lo_a,
  input  logic [HALF_W-1:0] lo_b,
  input  logic              lo_cin,
  input  logic              lo_in_vld,
  input  logic [HALF_W-1:0] hi_a,
  input  logic [HALF_W-1:0] hi_b,
  input  logic              hi_in_vld,
  output logic [HALF_W-1:0] lo_sum,
  output logic              lo_out_vld,
  output logic [HALF_W-1:0] hi_sum,
  output logic              hi_cout,
  output logic              hi_out_vld
);
  logic              carry_q;
  logic [HALF_W:0]   lc, hc;
  logic [HALF_W-1:0] lsum_w, hsum_w;

  assign lc[0] = lo_cin;
  assign hc[0] = carry_q;

  for (genvar i = 0; i < HALF_W; i++) begin : g_fa
    assign lsum_w[i]  = lo_a[i] ^ lo_b[i] ^ lc[i];
    assign lc[i+1]    = (lo_a[i] & lo_b[i]) | (lc[i] & (lo_a[i] ^ lo_b[i]));
    assign hsum_w[i]  = hi_a[i] ^ hi_b[i] ^ hc[i];
    assign hc[i+1]    = (hi_a[i] & hi_b[i]) | (hc[i] & (hi_a[i] ^ hi_b[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q    <= 1'b0;
      lo_sum     <= '0;
      lo_out_vld <= 1'b0;
      hi_sum     <= '0;
      hi_cout    <= 1'b0;
      hi_out_vld <= 1'b0;
    end else begin
      carry_q    <= lo_in_vld & lc[HALF_W];
      lo_sum     <= lsum_w;
      lo_out_vld <= lo_in_vld;
      hi_sum     <= hsum_w;
      hi_cout    <= hc[HALF_W];
      hi_out_vld <= hi_in_vld;
    end
  end
endmodule

module skew_pipe_adder_chk #(
  parameter int HALF_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [HALF_W-1:0] lo_a,
  input logic [HALF_W-1:0] lo_b,
  input logic              lo_cin,
  input logic              lo_in_vld,
  input logic [HALF_W-1:0] hi_a,
  input logic [HALF_W-1:0] hi_b,
  input logic              hi_in_vld,
  input logic [HALF_W-1:0] lo_sum,
  input logic              lo_out_vld,
  input logic [HALF_W-1:0] hi_sum,
  input logic              hi_cout,
  input logic              hi_out_vld
);
  logic [HALF_W:0]   lo_full, hi_full;
  logic [HALF_W-1:0] lo_low;
  logic              lo_carry_now;

  always_comb begin
    lo_full      = {1'b0, lo_a} + {1'b0, lo_b} + {{HALF_W{1'b0}}, lo_cin};
    hi_full      = {1'b0, hi_a} + {1'b0, hi_b};
    lo_low       = lo_full[HALF_W-1:0];
    lo_carry_now = lo_full[HALF_W];
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!lo_out_vld && !hi_out_vld && !hi_cout));

  p_lo_sum_r2: assert property (@(posedge clk) disable iff (rst)
    lo_in_vld |=> lo_sum == $past(lo_low));

  p_lo_vld_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> lo_out_vld == $past(lo_in_vld));

  p_hi_sum_r4: assert property (@(posedge clk) disable iff (rst)
    (hi_in_vld && $past(lo_in_vld) && !$past(rst))
    |=> {hi_cout, hi_sum} == $past(hi_full) + $past(lo_carry_now, 2));

  p_hi_vld_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> hi_out_vld == $past(hi_in_vld));

  p_no_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (hi_in_vld && (!$past(lo_in_vld) || $past(rst)))
    |=> {hi_cout, hi_sum} == $past(hi_full));
endmodule

bind skew_pipe_adder skew_pipe_adder_chk #(.HALF_W(HALF_W)) u_chk (.*);

// File: tb/skew_pipe_adder_test.sv
`timescale 1ns/1ps
module skew_pipe_adder_test;
  localparam int HW = 2;
  localparam int M  = 1 << HW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [HW-1:0] lo_a = '0, lo_b = '0, hi_a = '0, hi_b = '0;
  logic lo_cin = 1'b0, lo_in_vld = 1'b0, hi_in_vld = 1'b0;
  logic [HW-1:0] lo_sum, hi_sum;
  logic lo_out_vld, hi_cout, hi_out_vld;

  always #2 clk = ~clk;

  skew_pipe_adder #(.HALF_W(HW)) uut (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lo_expect(int a, int b, int c);
    return (a + b + c) % M;
  endfunction

  function automatic int carry_of(int a, int b, int c);
    return (a + b + c) / M;
  endfunction

  int p_la = 0, p_lb = 0, p_lc = 0, p_lv = 0;
  int pp_la = 0, pp_lb = 0, pp_lc = 0, pp_lv = 0;
  int p_ha = 0, p_hb = 0, p_hv = 0;
  int n_ha = 0, n_hb = 0, n_hv = 0;
  int last_lo = 0;

  initial begin
    int r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 lo_out_vld", lo_out_vld, 0);
    chk("R1 hi_out_vld", hi_out_vld, 0);
    chk("R1 lo_sum", lo_sum, 0);
    chk("R1 hi_sum", hi_sum, 0);
    chk("R1 hi_cout", hi_cout, 0);
    for (int n = 0; n < 3000; n++) begin
      int la, lb, lc, lv, carry, exp_hi, a_full, b_full;
      // outputs from inputs driven at the previous falling edge
      chk("R3 lo_out_vld", lo_out_vld, p_lv);
      if (p_lv != 0)
        chk("R2 lo_sum", lo_sum, lo_expect(p_la, p_lb, p_lc));
      chk("R6 hi_out_vld", hi_out_vld, p_hv);
      if (p_hv != 0) begin
        carry  = (pp_lv != 0) ? carry_of(pp_la, pp_lb, pp_lc) : 0;
        exp_hi = p_ha + p_hb + carry;
        if (pp_lv != 0) begin
          chk("R4 hi_sum", hi_sum, exp_hi % M);
          chk("R5 hi_cout", hi_cout, exp_hi / M);
          a_full = p_ha * M + pp_la;
          b_full = p_hb * M + pp_lb;
          chk("R8 full sum", (hi_cout * M + hi_sum) * M + last_lo,
              a_full + b_full + pp_lc);
        end else begin
          chk("R7 hi no carry", hi_cout * M + hi_sum, p_ha + p_hb);
        end
      end
      last_lo = lo_sum;

      // choose the next stimulus
      if (n < 4) begin
        lv = 1;
        case (n)
          0: begin la = M-1; lb = M-1; lc = 1; end
          1: begin la = M-1; lb = 1;   lc = 0; end
          2: begin la = 0;   lb = 0;   lc = 0; end
          default: begin la = 1; lb = 2; lc = 0; end
        endcase
      end else if (n == 4) begin
        lv = 0; la = M-1; lb = M-1; lc = 1;
      end else begin
        r  = int'($urandom % 10);
        lv = (r < 8) ? 1 : 0;
        la = int'($urandom % M);
        lb = int'($urandom % M);
        lc = int'($urandom % 2);
      end

      pp_la = p_la; pp_lb = p_lb; pp_lc = p_lc; pp_lv = p_lv;
      p_la = la; p_lb = lb; p_lc = lc; p_lv = lv;
      p_ha = n_ha; p_hb = n_hb; p_hv = n_hv;

      lo_a = la[HW-1:0]; lo_b = lb[HW-1:0]; lo_cin = lc[0]; lo_in_vld = lv[0];
      hi_a = n_ha[HW-1:0]; hi_b = n_hb[HW-1:0]; hi_in_vld = n_hv[0];

      // high half for next cycle: paired with this low half, or an orphan
      if (lv != 0) begin
        case (n)
          0: begin n_ha = M-1; n_hb = M-1; end
          1: begin n_ha = 0;   n_hb = 0;   end
          2: begin n_ha = 0;   n_hb = 0;   end
          3: begin n_ha = M-1; n_hb = 1;   end
          default: begin n_ha = int'($urandom % M); n_hb = int'($urandom % M); end
        endcase
        n_hv = 1;
      end else begin
        n_ha = (n == 4) ? M-1 : int'($urandom % M);
        n_hb = (n == 4) ? 0   : int'($urandom % M);
        n_hv = (n == 4) ? 1 : (($urandom % 2) == 0 ? 1 : 0);
      end
      @(negedge clk);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule